// File: doc/BRIEF.md
# Isochronous Bus Cycle Timer

This block keeps the bus time for an isochronous serial bus as one packed 32-bit word with three fields. A sub-cycle offset counts tick-clock periods from 0 to 3071, so one bus cycle is 3072 ticks. A cycle count runs from 0 to 7999, so one second is 8000 cycles. A 7-bit seconds count wraps modulo 128. The tick clock runs at a nominal 24.576 MHz. It reaches the block as a one-cycle `tick_en` qualifier in the system clock domain. The block advances the word by one tick for each qualified cycle.

Every field and every carry is held in the same register bank and updated on one clock edge. The word on `time_word` is therefore always coherent: no read can see a wrapped offset next to a cycle count that has not yet moved. Software or a protocol engine sets the time through a synchronous load port.

Each toggle of the top seconds bit marks a 64-second rollover. The block reports it as a one-cycle pulse and also as a sticky flag, which `roll_clear` clears.

Top module: `cycle_timer`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `time_word`, `roll_pulse` and `roll_sticky` are all zero.
- R2: The offset field is `time_word[11:0]`. Each clock edge with `tick_en` high and `load` low adds one to it. An edge with both `tick_en` and `load` low leaves the whole word unchanged.
- R3: A counted tick that finds the offset at 3071 sets the offset to 0 and adds one to the cycle count field `time_word[24:12]`. Both changes happen on the same edge.
- R4: A counted tick that finds the offset at 3071 and the cycle count at 7999 sets both to 0 and adds one to the seconds field `time_word[31:25]`.
- R5: The seconds field steps from 127 to 0 on its carry.
- R6: An edge with `load` high copies `load_value` into all three fields at once, whatever the value of `tick_en`.
- R7: A loaded offset above 3071 behaves like 3071 at the next counted tick: it wraps to 0 and carries. A loaded cycle count above 7999 behaves like 7999 when it receives a carry.
- R8: `roll_pulse` is high for exactly the one cycle in which the word first shows a seconds value whose top bit (`time_word[31]`) was changed by counting. A load that changes that bit raises no pulse.
- R9: `roll_sticky` rises together with `roll_pulse` and stays high until an edge with `roll_clear` high and no new pulse. If a pulse and a clear fall on the same edge, the flag stays set.
- R10: `roll_clear` does not change `time_word`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One tick-clock period has elapsed |
| load | input | 1 | Write `load_value` into the timer |
| load_value | input | 32 | Packed time word to load |
| roll_clear | input | 1 | Clear the sticky rollover flag |
| time_word | output | 32 | Packed seconds, cycle count and offset |
| roll_pulse | output | 1 | One-cycle 64-second rollover event |
| roll_sticky | output | 1 | Sticky rollover flag |

## Verification
The bench loads values next to each wrap point so that the carry chain is exercised in a few cycles. A design that carried late would show a zero offset beside a stale cycle count. A design that compared against a power-of-two limit would run the offset past 3071 or the count past 7999. The 127-to-0 seconds step and the 63-to-64 step must each give exactly one pulse, while a load across the same bit must give none; a design that watched the bit rather than the carry would pulse on the load. All-ones loads check that out-of-range fields wrap instead of counting on to their binary maximum. A pulse and a clear on the same edge check that the sticky flag gives the set priority.

// File: rtl/cycle_timer.sv
module cycle_timer #(
  parameter int OFFSET_W     = 12,
  parameter int OFFSET_LIMIT = 3072,
  parameter int COUNT_W      = 13,
  parameter int COUNT_LIMIT  = 8000,
  parameter int SEC_W        = 7,
  localparam int WORD_W      = OFFSET_W + COUNT_W + SEC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              load,
  input  logic [WORD_W-1:0] load_value,
  input  logic              roll_clear,
  output logic [WORD_W-1:0] time_word,
  output logic              roll_pulse,
  output logic              roll_sticky
);

  localparam logic [OFFSET_W-1:0] OFF_LAST = OFFSET_W'(OFFSET_LIMIT - 1);
  localparam logic [COUNT_W-1:0]  CNT_LAST = COUNT_W'(COUNT_LIMIT - 1);
  localparam int CNT_LSB = OFFSET_W;
  localparam int SEC_LSB = OFFSET_W + COUNT_W;

  logic [OFFSET_W-1:0] offset_q, offset_n;
  logic [COUNT_W-1:0]  count_q, count_n;
  logic [SEC_W-1:0]    sec_q, sec_n;
  logic                off_wrap, cnt_wrap, roll_now;

  assign off_wrap = offset_q >= OFF_LAST;
  assign cnt_wrap = off_wrap && (count_q >= CNT_LAST);

  assign offset_n = off_wrap ? '0 : offset_q + 1'b1;
  assign count_n  = cnt_wrap ? '0 : (off_wrap ? count_q + 1'b1 : count_q);
  assign sec_n    = cnt_wrap ? sec_q + 1'b1 : sec_q;

  assign roll_now = tick_en && !load && cnt_wrap &&
                    (sec_n[SEC_W-1] != sec_q[SEC_W-1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      offset_q <= '0;
      count_q  <= '0;
      sec_q    <= '0;
    end else if (load) begin
      offset_q <= load_value[CNT_LSB-1:0];
      count_q  <= load_value[SEC_LSB-1:CNT_LSB];
      sec_q    <= load_value[WORD_W-1:SEC_LSB];
    end else if (tick_en) begin
      offset_q <= offset_n;
      count_q  <= count_n;
      sec_q    <= sec_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      roll_pulse  <= 1'b0;
      roll_sticky <= 1'b0;
    end else begin
      roll_pulse  <= roll_now;
      roll_sticky <= roll_now || (roll_sticky && !roll_clear);
    end
  end

  assign time_word = {sec_q, count_q, offset_q};

endmodule

// File: rtl/cycle_timer_chk.sv
module cycle_timer_chk #(
  parameter int OFFSET_W     = 12,
  parameter int OFFSET_LIMIT = 3072,
  parameter int COUNT_W      = 13,
  parameter int COUNT_LIMIT  = 8000,
  parameter int SEC_W        = 7,
  localparam int WORD_W      = OFFSET_W + COUNT_W + SEC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              load,
  input logic [WORD_W-1:0] load_value,
  input logic              roll_clear,
  input logic [WORD_W-1:0] time_word,
  input logic              roll_pulse,
  input logic              roll_sticky
);

  localparam logic [OFFSET_W-1:0] OFF_LAST = OFFSET_W'(OFFSET_LIMIT - 1);
  localparam int SEC_LSB = OFFSET_W + COUNT_W;

  logic [OFFSET_W-1:0] off_f;
  logic [COUNT_W-1:0]  cnt_f;
  assign off_f = time_word[OFFSET_W-1:0];
  assign cnt_f = time_word[SEC_LSB-1:OFFSET_W];

  a_r2_offset_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en && !load && off_f < OFF_LAST |=>
      time_word[OFFSET_W-1:0] == $past(off_f) + 1'b1);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en && !load |=> $stable(time_word));

  a_r3_same_edge_carry: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en && !load && off_f == OFF_LAST && cnt_f < COUNT_W'(COUNT_LIMIT - 1) |=>
      time_word[OFFSET_W-1:0] == '0 && time_word[SEC_LSB-1:OFFSET_W] == $past(cnt_f) + 1'b1);

  a_r6_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> time_word == $past(load_value));

  a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    roll_pulse |=> !roll_pulse);

  a_r8_no_pulse_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !roll_pulse);

  a_r9_sticky_follows: assert property (@(posedge clk) disable iff (!rst_n)
    roll_pulse |-> roll_sticky);

  a_r9_sticky_clear: assert property (@(posedge clk) disable iff (!rst_n)
    roll_clear && !roll_pulse |=> roll_pulse || !roll_sticky);

endmodule

bind cycle_timer cycle_timer_chk #(
  .OFFSET_W(OFFSET_W), .OFFSET_LIMIT(OFFSET_LIMIT), .COUNT_W(COUNT_W),
  .COUNT_LIMIT(COUNT_LIMIT), .SEC_W(SEC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load(load),
  .load_value(load_value), .roll_clear(roll_clear), .time_word(time_word),
  .roll_pulse(roll_pulse), .roll_sticky(roll_sticky)
);

// File: tb/cycle_timer_tb.sv
module cycle_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        load = 1'b0;
  logic [31:0] load_value = '0;
  logic        roll_clear = 1'b0;
  logic [31:0] time_word;
  logic        roll_pulse;
  logic        roll_sticky;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] exp_word = '0;
  logic        exp_pulse = 1'b0;
  logic        exp_sticky = 1'b0;

  always #2 clk = ~clk;

  cycle_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load(load),
    .load_value(load_value), .roll_clear(roll_clear), .time_word(time_word),
    .roll_pulse(roll_pulse), .roll_sticky(roll_sticky)
  );

  function automatic logic [31:0] advance(input logic [31:0] w, output logic ev);
    logic [11:0] o = w[11:0];
    logic [12:0] c = w[24:12];
    logic [6:0]  s = w[31:25];
    logic [6:0]  s0 = w[31:25];
    ev = 1'b0;
    if (o >= 12'd3071) begin
      o = '0;
      if (c >= 13'd7999) begin
        c = '0;
        s = s + 7'd1;
        ev = (s[6] != s0[6]);
      end else c = c + 13'd1;
    end else o = o + 12'd1;
    return {s, c, o};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " word"}, time_word, exp_word);
    check({tag, " pulse"}, {31'd0, roll_pulse}, {31'd0, exp_pulse});
    check({tag, " sticky"}, {31'd0, roll_sticky}, {31'd0, exp_sticky});
  endtask

  task automatic step(input logic t, input logic ld, input logic [31:0] v,
                      input logic clr, input string tag);
    logic ev;
    logic [31:0] nw;
    tick_en = t; load = ld; load_value = v; roll_clear = clr;
    ev = 1'b0;
    nw = exp_word;
    if (ld) nw = v;
    else if (t) nw = advance(exp_word, ev);
    exp_word = nw;
    exp_sticky = ev | (exp_sticky & ~clr);
    exp_pulse = ev;
    @(posedge clk);
    #1;
    check_all(tag);
  endtask

  function automatic logic [31:0] pack(input int s, input int c, input int o);
    return {7'(s), 13'(c), 12'(o)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check_all("R1 in reset");
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check_all("R1 after reset");

    // R2 counting and hold
    step(1, 0, 0, 0, "R2 tick");
    step(1, 0, 0, 0, "R2 tick");
    step(0, 0, 0, 0, "R2 hold");
    check("R2 offset two", time_word, 32'd2);

    // R3 offset wrap with same-edge carry
    step(0, 1, pack(0, 5, 3070), 0, "R6 load");
    step(1, 0, 0, 0, "R2 to 3071");
    step(1, 0, 0, 0, "R3 wrap");
    check("R3 carried", time_word, pack(0, 6, 0));

    // R4 cycle count wrap into seconds
    step(0, 1, pack(10, 7999, 3071), 0, "R6 load");
    step(1, 0, 0, 0, "R4 wrap");
    check("R4 seconds", time_word, pack(11, 0, 0));

    // R8 63 -> 64 raises pulse, R9 sticky
    step(0, 1, pack(63, 7999, 3071), 0, "R6 load");
    step(1, 0, 0, 0, "R8 rise");
    check("R8 pulse 63to64", {31'd0, roll_pulse}, 32'd1);
    step(1, 0, 0, 0, "R8 one cycle");
    step(0, 0, 0, 1, "R9 clear");
    check("R9 cleared", {31'd0, roll_sticky}, 32'd0);

    // R5 127 -> 0 and R9 set beats clear
    step(0, 1, pack(127, 7999, 3071), 0, "R6 load");
    step(1, 0, 0, 1, "R5 wrap with clear");
    check("R5 seconds zero", time_word, 32'd0);
    check("R9 set wins", {31'd0, roll_sticky}, 32'd1);

    // R8 load across the top bit gives no pulse; R10 clear leaves word
    step(0, 1, pack(64, 100, 7), 0, "R8 load no pulse");
    step(1, 1, pack(63, 1, 1), 0, "R6 load beats tick");
    step(0, 0, 0, 1, "R10 clear keeps word");
    check("R10 word", time_word, pack(63, 1, 1));

    // R7 out-of-range fields
    step(0, 1, 32'hFFFF_FFFF, 0, "R7 load ones");
    step(1, 0, 0, 0, "R7 wrap all");
    check("R7 all wrapped", time_word, 32'd0);
    step(0, 1, pack(3, 8100, 4000), 0, "R7 load");
    step(1, 0, 0, 0, "R7 wrap");
    check("R7 to next second", time_word, pack(4, 0, 0));

    // random mix (R2..R10)
    for (int i = 0; i < 6000; i++) begin
      logic t, ld, clr;
      logic [31:0] v;
      t = ($urandom % 4) != 0;
      ld = ($urandom % 48) == 0;
      clr = ($urandom % 16) == 0;
      case ($urandom % 3)
        0: v = $urandom;
        1: v = pack($urandom % 128, 7990 + ($urandom % 10), 3060 + ($urandom % 12));
        default: v = pack((($urandom % 2) ? 63 : 127), 7999, 3068 + ($urandom % 4));
      endcase
      step(t, ld, v, clr, "R2-random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule